// File: doc/BRIEF.md
# Masked Content-Addressable Lookup Engine

This block is a small associative lookup table. Each stored entry is 64 bits wide. The low part is the match field and the rest is the output field. A programmable width sets where the two meet. A global mask register turns selected key bits into don't-care positions. An optional cell-switching mode lets path-level entries match on the upper key bits alone, while circuit-level entries in the same table must match the full key.

The search key arrives over a shared 32-bit bidirectional bus. When the match field is wider than 32 bits, a low-half strobe first captures the low 32 key bits. A high-half/start strobe then captures the remaining bits and starts the search. A fixed number of cycles later the engine raises a completion flag, together with a success flag when a valid entry hit. When the output-enable input is low, the engine drives the winning entry's output field back onto the same bus. A simple write port loads entries, the mask and the mode. Start strobes must be spaced out in time; an early start is dropped and recorded in a sticky error flag.

Top module: `masked_cam_engine`

## Requirements
- R1: After reset, `match_done`, `match_hit`, `path_hit` and `start_err` are 0, and every entry is invalid, so any search misses until entries are written again. Reset sets the match width to 32, clears the mask and leaves path mode off.
- R2: With match width W of 32 or less, the key is taken from bus bits [W-1:0] at the start strobe. On a hit, the data read back is bits [W+31:W] of the winning entry; bits above 63 read as 0.
- R3: With W above 32, the key's low 32 bits come from the bus at the most recent `latch_lo` strobe, and its bits 63:32 come from the bus at the start strobe.
- R4: A mask bit of 1 (written with `wr_kind`=1; mask bit i covers key bit i) excludes that key bit from the comparison.
- R5: When a start strobe is sampled at clock edge E and accepted, `match_done` is 0 after edges E through E+8 and is 1 after edge E+9. It stays 1 until the next accepted start or reset.
- R6: A search that finds no matching valid entry ends with `match_done`=1 and `match_hit`=0.
- R7: When several valid entries match, the one with the lowest index provides the result.
- R8: A start strobe sampled fewer than 11 edges after the last accepted start is ignored: the key and the search in progress are unchanged. It sets `start_err`, which stays 1 until reset.
- R9: An accepted start clears `match_done`, `match_hit` and `path_hit` at that edge.
- R10: The engine drives `mq` only while `match_hit`=1 and `oe_n`=0. At all other times it releases the bus.
- R11: The mode write (`wr_kind`=2) takes the width from `wr_data[6:0]` (0 or a value above 64 means 64) and path mode from `wr_data[8]`. In path mode, entries written with `wr_path`=1 ignore key bits [15:0], and `path_hit` is 1 with a hit whose winner is such an entry. Outside path mode, these entries compare normally and `path_hit` stays 0.
- R12: An entry written (`wr_kind`=0) with `wr_valid`=0 never matches, even when it is the lowest-indexed entry whose bits match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the write port |
| wr_kind | input | 2 | 0 entry, 1 mask, 2 mode, 3 no effect |
| wr_index | input | 4 | Entry index for entry writes |
| wr_data | input | 64 | Entry contents, mask bits or mode word |
| wr_valid | input | 1 | Valid bit stored with an entry |
| wr_path | input | 1 | Path-level marker stored with an entry |
| latch_lo | input | 1 | Captures the low 32 key bits from `mq` |
| start_hi | input | 1 | Captures the upper key bits and starts a search |
| oe_n | input | 1 | Active-low output enable for the result |
| mq | inout | 32 | Shared key-in / result-out bus |
| match_done | output | 1 | Search complete |
| match_hit | output | 1 | A valid entry matched |
| path_hit | output | 1 | The winner was a path-level entry in path mode |
| start_err | output | 1 | Sticky flag for a start that came too early |

## Verification
The spacing guard and an in-flight search overlap: a second start strobe arrives three cycles into a search, while the countdown is still running. The bench then checks that `start_err` rises, that completion still comes nine cycles after the first strobe, and that the flags and read-back data belong to the first key rather than the rejected one. A further start, sent once the 11-cycle window has elapsed, must clear the flags on its own edge. In the overlap of the latch strobe and the start strobe in wide mode, the low half must come from the earlier `latch_lo` cycle, not from the bus value at start.

// File: rtl/cam_pkg.sv
package cam_pkg;
  typedef enum logic [1:0] {
    WK_ENTRY = 2'd0,
    WK_MASK  = 2'd1,
    WK_MODE  = 2'd2,
    WK_NONE  = 2'd3
  } wr_kind_e;
endpackage

// File: rtl/cam_cfg_regs.sv
module cam_cfg_regs
  import cam_pkg::*;
#(
  parameter int ENTRY_W = 64,
  parameter int BUS_W   = 32,
  parameter int ATM_BIT = 8,
  localparam int WID_W  = $clog2(ENTRY_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_kind,
  input  logic [ENTRY_W-1:0] wr_data,
  output logic [WID_W-1:0]   width,
  output logic [ENTRY_W-1:0] mask,
  output logic               atm
);
  logic [WID_W-1:0]   width_q, width_d;
  logic [ENTRY_W-1:0] mask_q, mask_d;
  logic               atm_q, atm_d;
  logic [WID_W-1:0]   width_raw;
  wr_kind_e           kind;

  assign kind      = wr_kind_e'(wr_kind);
  assign width_raw = wr_data[WID_W-1:0];

  always_comb begin
    width_d = width_q;
    mask_d  = mask_q;
    atm_d   = atm_q;
    if (wr_en && kind == WK_MASK) begin
      mask_d = wr_data;
    end
    if (wr_en && kind == WK_MODE) begin
      atm_d = wr_data[ATM_BIT];
      if (width_raw == '0 || width_raw > WID_W'(ENTRY_W)) begin
        width_d = WID_W'(ENTRY_W);
      end else begin
        width_d = width_raw;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q <= WID_W'(BUS_W);
      mask_q  <= '0;
      atm_q   <= 1'b0;
    end else begin
      width_q <= width_d;
      mask_q  <= mask_d;
      atm_q   <= atm_d;
    end
  end

  assign width = width_q;
  assign mask  = mask_q;
  assign atm   = atm_q;
endmodule

// File: rtl/cam_key_latch.sv
module cam_key_latch #(
  parameter int ENTRY_W = 64,
  parameter int BUS_W   = 32,
  localparam int WID_W  = $clog2(ENTRY_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               latch_lo,
  input  logic               start_acc,
  input  logic [BUS_W-1:0]   bus_in,
  input  logic [WID_W-1:0]   width,
  output logic [ENTRY_W-1:0] key
);
  // The key is two bus halves, so ENTRY_W is expected to be 2*BUS_W.
  logic [BUS_W-1:0]   lo_q, lo_d;
  logic [ENTRY_W-1:0] key_q, key_d;

  always_comb begin
    lo_d  = lo_q;
    key_d = key_q;
    if (latch_lo) begin
      lo_d = bus_in;
    end
    if (start_acc) begin
      if (width > WID_W'(BUS_W)) begin
        key_d = {bus_in, lo_q};
      end else begin
        key_d = {{(ENTRY_W-BUS_W){1'b0}}, bus_in};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      key_q <= '0;
    end else begin
      lo_q  <= lo_d;
      key_q <= key_d;
    end
  end

  assign key = key_q;
endmodule

// File: rtl/cam_store.sv
module cam_store #(
  parameter int ENTRIES = 16,
  parameter int ENTRY_W = 64,
  parameter int BUS_W   = 32,
  parameter int VCI_W   = 16,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int WID_W  = $clog2(ENTRY_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_index,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic               wr_valid,
  input  logic               wr_path,
  input  logic [ENTRY_W-1:0] key,
  input  logic [WID_W-1:0]   width,
  input  logic [ENTRY_W-1:0] mask,
  input  logic               atm,
  output logic               hit,
  output logic               hit_path,
  output logic [BUS_W-1:0]   hit_data
);
  localparam logic [ENTRY_W-1:0] LOW_KEEP =
    {{(ENTRY_W-VCI_W){1'b0}}, {VCI_W{1'b1}}};

  logic [ENTRY_W-1:0] ent_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [ENTRIES-1:0] path_q, path_d;
  logic [ENTRY_W-1:0] en_base, en_path;
  logic [ENTRIES-1:0] hit_vec;
  logic [IDX_W-1:0]   win_idx;
  logic [ENTRY_W-1:0] shifted;

  // Compare enables: inside the match width and not masked.
  for (genvar b = 0; b < ENTRY_W; b++) begin : g_en
    assign en_base[b] = (WID_W'(b) < width) && !mask[b];
  end
  assign en_path = atm ? (en_base & ~LOW_KEEP) : en_base;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    logic [ENTRY_W-1:0] en_e;
    assign en_e       = path_q[e] ? en_path : en_base;
    assign hit_vec[e] = valid_q[e] && (((ent_q[e] ^ key) & en_e) == '0);
  end

  // Lowest index wins.
  always_comb begin
    hit     = 1'b0;
    win_idx = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (hit_vec[e]) begin
        hit     = 1'b1;
        win_idx = IDX_W'(e);
      end
    end
  end

  assign hit_path = path_q[win_idx];
  assign shifted  = ent_q[win_idx] >> width;
  assign hit_data = shifted[BUS_W-1:0];

  always_comb begin
    valid_d = valid_q;
    path_d  = path_q;
    if (wr_en) begin
      valid_d[wr_index] = wr_valid;
      path_d[wr_index]  = wr_path;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      path_q  <= '0;
    end else begin
      valid_q <= valid_d;
      path_q  <= path_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_q[wr_index] <= wr_data;
    end
  end

  a_r12_winner_valid: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> valid_q[win_idx]);
endmodule

// File: rtl/cam_seq.sv
module cam_seq #(
  parameter int BUS_W   = 32,
  parameter int LATENCY = 9,
  parameter int SPACING = 11,
  localparam int CNT_W  = $clog2(LATENCY + 1),
  localparam int GAP_W  = $clog2(SPACING)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_hi,
  input  logic             hit,
  input  logic             hit_path,
  input  logic             atm,
  input  logic [BUS_W-1:0] hit_data,
  output logic             start_acc,
  output logic             done,
  output logic             found,
  output logic             path_found,
  output logic [BUS_W-1:0] result,
  output logic             err
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic             mc_q, mc_d, ms_q, ms_d, vp_q, vp_d, err_q, err_d;
  logic             finish;
  logic [BUS_W-1:0] res_q;

  assign start_acc = start_hi && (gap_q == '0);
  assign finish    = !start_acc && (cnt_q == CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    gap_d = gap_q;
    mc_d  = mc_q;
    ms_d  = ms_q;
    vp_d  = vp_q;
    err_d = err_q | (start_hi && !start_acc);
    if (start_acc) begin
      cnt_d = CNT_W'(LATENCY);
      gap_d = GAP_W'(SPACING - 1);
      mc_d  = 1'b0;
      ms_d  = 1'b0;
      vp_d  = 1'b0;
    end else begin
      if (gap_q != '0) gap_d = gap_q - GAP_W'(1);
      if (cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
      if (finish) begin
        mc_d = 1'b1;
        ms_d = hit;
        vp_d = hit && hit_path && atm;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      gap_q <= '0;
      mc_q  <= 1'b0;
      ms_q  <= 1'b0;
      vp_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      gap_q <= gap_d;
      mc_q  <= mc_d;
      ms_q  <= ms_d;
      vp_q  <= vp_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk) begin
    if (finish) begin
      res_q <= hit_data;
    end
  end

  assign done       = mc_q;
  assign found      = ms_q;
  assign path_found = vp_q;
  assign result     = res_q;
  assign err        = err_q;

  a_r5_hit_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    ms_q |-> mc_q);
  a_r5_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_q && !start_acc) |=> mc_q);
  a_r8_early_start_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (start_hi && !start_acc) |=> err_q);
  a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (!mc_q && !ms_q && !vp_q));
endmodule

// File: rtl/masked_cam_engine.sv
module masked_cam_engine
  import cam_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ENTRY_W = 64,
  parameter int BUS_W   = 32,
  parameter int VCI_W   = 16,
  parameter int LATENCY = 9,
  parameter int SPACING = 11,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int WID_W  = $clog2(ENTRY_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_kind,
  input  logic [IDX_W-1:0]   wr_index,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic               wr_valid,
  input  logic               wr_path,
  input  logic               latch_lo,
  input  logic               start_hi,
  input  logic               oe_n,
  inout  wire  [BUS_W-1:0]   mq,
  output logic               match_done,
  output logic               match_hit,
  output logic               path_hit,
  output logic               start_err
);
  logic [1:0]         rst_sync_q;
  logic               rst_n_s;
  logic [WID_W-1:0]   width;
  logic [ENTRY_W-1:0] mask;
  logic               atm;
  logic [ENTRY_W-1:0] key;
  logic               start_acc;
  logic               hit, hit_path;
  logic [BUS_W-1:0]   hit_data, result;
  logic               ent_wr;

  // Reset asserts at once and releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign ent_wr = wr_en && (wr_kind_e'(wr_kind) == WK_ENTRY);

  cam_cfg_regs #(.ENTRY_W(ENTRY_W), .BUS_W(BUS_W)) u_cfg (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .wr_kind(wr_kind),
    .wr_data(wr_data), .width(width), .mask(mask), .atm(atm));

  cam_key_latch #(.ENTRY_W(ENTRY_W), .BUS_W(BUS_W)) u_key (
    .clk(clk), .rst_n(rst_n_s), .latch_lo(latch_lo), .start_acc(start_acc),
    .bus_in(mq), .width(width), .key(key));

  cam_store #(.ENTRIES(ENTRIES), .ENTRY_W(ENTRY_W), .BUS_W(BUS_W),
              .VCI_W(VCI_W)) u_store (
    .clk(clk), .rst_n(rst_n_s), .wr_en(ent_wr), .wr_index(wr_index),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_path(wr_path), .key(key),
    .width(width), .mask(mask), .atm(atm), .hit(hit), .hit_path(hit_path),
    .hit_data(hit_data));

  cam_seq #(.BUS_W(BUS_W), .LATENCY(LATENCY), .SPACING(SPACING)) u_seq (
    .clk(clk), .rst_n(rst_n_s), .start_hi(start_hi), .hit(hit),
    .hit_path(hit_path), .atm(atm), .hit_data(hit_data),
    .start_acc(start_acc), .done(match_done), .found(match_hit),
    .path_found(path_hit), .result(result), .err(start_err));

  assign mq = (match_hit && !oe_n) ? result : {BUS_W{1'bz}};

  a_r11_path_implies_hit: assert property (@(posedge clk) disable iff (!rst_n_s)
    path_hit |-> match_hit);
endmodule

// File: tb/masked_cam_engine_tb.sv
module masked_cam_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_valid, wr_path, latch_lo, start_hi, oe_n;
  logic [1:0]  wr_kind;
  logic [3:0]  wr_index;
  logic [63:0] wr_data;
  logic        drv_en;
  logic [31:0] drv_val;
  wire  [31:0] mq_w;
  logic        match_done, match_hit, path_hit, start_err;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  assign mq_w = drv_en ? drv_val : 32'bz;

  masked_cam_engine dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
    .wr_index(wr_index), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_path(wr_path), .latch_lo(latch_lo), .start_hi(start_hi),
    .oe_n(oe_n), .mq(mq_w), .match_done(match_done), .match_hit(match_hit),
    .path_hit(path_hit), .start_err(start_err));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] kind, input int idx, input logic [63:0] data,
                    input logic valid, input logic path);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = kind; wr_index = 4'(idx);
    wr_data = data; wr_valid = valid; wr_path = path;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Issues a search and checks the completion latency (R5).
  task automatic search(input logic [31:0] hi, input logic [31:0] lo, input bit use_lo);
    if (use_lo) begin
      @(negedge clk);
      drv_en = 1'b1; drv_val = lo; latch_lo = 1'b1;
      @(negedge clk);
      latch_lo = 1'b0;
    end else begin
      @(negedge clk);
    end
    drv_en = 1'b1; drv_val = hi; start_hi = 1'b1;
    @(negedge clk);
    start_hi = 1'b0; drv_en = 1'b0;
    repeat (8) @(negedge clk);
    chk("R5 done low before edge 9", 64'(match_done), 64'd0);
    @(negedge clk);
    chk("R5 done high after edge 9", 64'(match_done), 64'd1);
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_res(input string tag, input bit hit, input logic [31:0] data,
                            input bit vp);
    chk({tag, " hit"}, 64'(match_hit), 64'(hit));
    chk({tag, " path"}, 64'(path_hit), 64'(vp));
    if (hit) begin
      oe_n = 1'b0;
      #2;
      chk({tag, " data"}, 64'(mq_w), 64'(data));
      oe_n = 1'b1;
    end
  endtask

  task automatic t_reset_state();
    chk("R1 done after reset", 64'(match_done), 64'd0);
    chk("R1 hit after reset", 64'(match_hit), 64'd0);
    chk("R1 path after reset", 64'(path_hit), 64'd0);
    chk("R1 err after reset", 64'(start_err), 64'd0);
  endtask

  task automatic t_basic();
    wr(2'd0, 3, 64'hCAFEF00D_12345678, 1'b1, 1'b0);
    wr(2'd0, 6, 64'h00005555_0000BEEF, 1'b1, 1'b0);
    search(32'h12345678, 32'h0, 1'b0);
    expect_res("R2 narrow key", 1'b1, 32'hCAFEF00D, 1'b0);
    // R10: released bus carries the bench's own value.
    @(negedge clk);
    oe_n = 1'b1; drv_en = 1'b1; drv_val = 32'h5A5A_0F0F;
    #2;
    chk("R10 bus released when oe_n high", 64'(mq_w), 64'h5A5A0F0F);
    drv_en = 1'b0;
    search(32'h12345679, 32'h0, 1'b0);
    expect_res("R6 miss", 1'b0, 32'h0, 1'b0);
    oe_n = 1'b0; drv_en = 1'b1; drv_val = 32'h1357_9BDF;
    #2;
    chk("R10 bus released on miss", 64'(mq_w), 64'h13579BDF);
    drv_en = 1'b0; oe_n = 1'b1;
  endtask

  task automatic t_spacing();
    @(negedge clk);
    drv_en = 1'b1; drv_val = 32'h12345678; start_hi = 1'b1;
    @(negedge clk);
    start_hi = 1'b0;
    repeat (2) @(negedge clk);
    drv_val = 32'h0BAD0BAD; start_hi = 1'b1;
    @(negedge clk);
    start_hi = 1'b0; drv_en = 1'b0;
    chk("R8 early start sets err", 64'(start_err), 64'd1);
    repeat (5) @(negedge clk);
    chk("R8 first search still pending", 64'(match_done), 64'd0);
    @(negedge clk);
    chk("R8 first search completes on time", 64'(match_done), 64'd1);
    expect_res("R8 first key kept", 1'b1, 32'hCAFEF00D, 1'b0);
    @(negedge clk);
    @(negedge clk);
    drv_en = 1'b1; drv_val = 32'h0BAD0BAD; start_hi = 1'b1;
    @(negedge clk);
    start_hi = 1'b0; drv_en = 1'b0;
    chk("R9 done cleared by start", 64'(match_done), 64'd0);
    chk("R9 hit cleared by start", 64'(match_hit), 64'd0);
    repeat (9) @(negedge clk);
    chk("R8 err stays sticky", 64'(start_err), 64'd1);
    expect_res("R9 second search misses", 1'b0, 32'h0, 1'b0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_wide();
    wr(2'd2, 0, 64'd40, 1'b0, 1'b0);
    wr(2'd0, 5, 64'hABCDEF12_3456789A, 1'b1, 1'b0);
    search(32'h00000012, 32'h3456789A, 1'b1);
    expect_res("R3 wide key", 1'b1, 32'h00ABCDEF, 1'b0);
    search(32'h00000013, 32'h3456789A, 1'b1);
    expect_res("R3 wide key upper bit differs", 1'b0, 32'h0, 1'b0);
  endtask

  task automatic t_mask();
    wr(2'd2, 0, 64'd16, 1'b0, 1'b0);
    wr(2'd1, 0, 64'h000F, 1'b0, 1'b0);
    search(32'h0000BEE0, 32'h0, 1'b0);
    expect_res("R4 masked nibble ignored", 1'b1, 32'h55550000, 1'b0);
    search(32'h0000BE0F, 32'h0, 1'b0);
    expect_res("R4 unmasked bits compared", 1'b0, 32'h0, 1'b0);
    wr(2'd1, 0, 64'h0, 1'b0, 1'b0);
  endtask

  task automatic t_priority();
    wr(2'd0, 2, 64'h00000000_00024242, 1'b0, 1'b0);
    wr(2'd0, 8, 64'h00000000_00084242, 1'b1, 1'b0);
    wr(2'd0, 10, 64'h00000000_000A4242, 1'b1, 1'b0);
    search(32'h00004242, 32'h0, 1'b0);
    expect_res("R7 lowest valid index wins", 1'b1, 32'h00000008, 1'b0);
    wr(2'd0, 1, 64'h00000000_00017777, 1'b0, 1'b0);
    search(32'h00007777, 32'h0, 1'b0);
    expect_res("R12 invalid entry never matches", 1'b0, 32'h0, 1'b0);
  endtask

  task automatic t_path_mode();
    wr(2'd2, 0, 64'h120, 1'b0, 1'b0);
    wr(2'd0, 12, 64'h00000C0C_00AB0000, 1'b1, 1'b1);
    wr(2'd0, 13, 64'h00000D0D_00AB0055, 1'b1, 1'b0);
    wr(2'd0, 14, 64'h00000E0E_00CD0055, 1'b1, 1'b0);
    search(32'h00AB0055, 32'h0, 1'b0);
    expect_res("R11 path entry wins", 1'b1, 32'h00000C0C, 1'b1);
    search(32'h00CD0055, 32'h0, 1'b0);
    expect_res("R11 circuit entry hit", 1'b1, 32'h00000E0E, 1'b0);
    wr(2'd2, 0, 64'd32, 1'b0, 1'b0);
    search(32'h00AB0099, 32'h0, 1'b0);
    expect_res("R11 path entry full compare when off", 1'b0, 32'h0, 1'b0);
    search(32'h00AB0055, 32'h0, 1'b0);
    expect_res("R11 circuit entry when mode off", 1'b1, 32'h00000D0D, 1'b0);
  endtask

  task automatic t_reset_clears();
    do_reset();
    t_reset_state();
    search(32'h12345678, 32'h0, 1'b0);
    expect_res("R1 entries invalid after reset", 1'b0, 32'h0, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_kind = 2'd3; wr_index = 4'd0; wr_data = '0;
    wr_valid = 1'b0; wr_path = 1'b0; latch_lo = 1'b0; start_hi = 1'b0;
    oe_n = 1'b1; drv_en = 1'b0; drv_val = '0;
    do_reset();
    t_reset_state();
    t_basic();
    t_spacing();
    t_wide();
    t_mask();
    t_priority();
    t_path_mode();
    t_reset_clears();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R5 watchdog act=running exp=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule